// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer whose control register is protected against stray writes. A prescaled tick advances a free-running count. If software does not kick the count before it reaches the selected limit, the block raises a reset request for one clock and starts counting again from zero. The control register holds an enable bit, a change-enable bit and a 3-bit period select, and software can read it back.

A safety-level input chooses how strict the register is. The block captures this input while reset is held and ignores it afterwards. At the open level, software may rewrite the period freely. At the guarded level, the period is protected as well. At the locked level, the watchdog can never be stopped. Each protected change needs two writes in order. The first write opens a short window. A second write inside that window commits the new values.

Top module: `wdt_guard`

## Requirements
- R1: After reset the register reads 0 at levels 0 and 1. At level 2 it reads only the enable bit set. Register layout: bit 4 is change-enable, bit 3 is enable, bits 2:0 are the period select.
- R2: At levels 0 and 1, any write with bit 3 = 1 sets the enable bit. No unlock is needed.
- R3: At level 0, every write loads bits 2:0 into the period select.
- R4: The enable bit clears only through a commit write while the window is open. At level 2 the enable bit always reads 1.
- R5: At levels 1 and 2, the period select changes only through a commit write while the window is open.
- R6: A write with bits 4 and 3 both 1 is an unlock write. It opens a window that stays open for the next four clocks. Bit 4 reads 1 while the window is open and clears by itself afterwards.
- R7: A commit write has bit 4 = 0 and lands in one of the four clocks after an unlock. It applies bit 3 and bits 2:0, except that level 2 keeps the enable bit at 1. Any write closes the window, unless that write is itself an unlock write. A write five clocks after the unlock is too late.
- R8: While enabled, the count advances on each tick. The timeout is 2^(BASE_LOG2+period) ticks. On the tick that reaches the timeout, `wdtReset` pulses high for one clock and the count restarts from zero.
- R9: A kick clears the count. A kick in the same clock as the expiring tick suppresses the pulse.
- R10: While disabled, the count stays at zero and `wdtReset` stays low.
- R11: The safety level is taken only while reset is asserted. Later changes to `safeLevel` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| safeLevel | input | 2 | Safety level (0, 1, 2; 3 acts as 2), captured while in reset |
| tick | input | 1 | Prescaled count enable |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 5 | Control write data |
| kick | input | 1 | Restart the timeout count |
| rdData | output | 5 | Control register read-back |
| wdtReset | output | 1 | One-clock timeout reset request |

## Verification
A kick and the expiring tick can land in the same clock. A commit write can also coincide with the last open clock of the window, or arrive one clock after the window closes. The bench lines up a kick with the exact tick on which the count would expire and expects no pulse. It also places commit writes on the fourth and fifth clock after an unlock, at every level, and expects the first to take effect and the second to be rejected. Random stimulus keeps producing more of these coincidences, and the bench judges every clock against its own cycle model.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  // width of the period select field
  localparam int PER_W   = 3;
  // clocks during which a commit write is accepted
  localparam int WIN_CYC = 4;
  localparam int CTL_W   = PER_W + 2;
  localparam int EN_BIT  = PER_W;
  localparam int CHG_BIT = PER_W + 1;
  localparam int WIN_W   = $clog2(WIN_CYC + 1);

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_GUARD  = 2'd1,
    LVL_LOCKED = 2'd2
  } safeLvl_t;

  // strobes from control to counter datapath
  typedef struct packed {
    logic             run;
    logic             restart;
    logic [PER_W-1:0] period;
  } cntCtl_t;
endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       safeLevel,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             kick,
  output logic [CTL_W-1:0] rdData,
  output cntCtl_t          cntCtl
);

  logic [1:0]       lvlQ;
  safeLvl_t         lvl;
  logic             enQ, enNext;
  logic [PER_W-1:0] perQ, perNext;
  logic [WIN_W-1:0] winCnt, winNext;
  logic             winOpen;
  logic             wrChg, wrEnb;
  logic [PER_W-1:0] wrPer;
  logic             unlockWr, commitWr;

  // level is latched only while reset is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlQ <= safeLevel;
    else       lvlQ <= lvlQ;
  end

  assign lvl = (lvlQ >= 2'd2) ? LVL_LOCKED : safeLvl_t'(lvlQ);

  assign wrChg    = wrData[CHG_BIT];
  assign wrEnb    = wrData[EN_BIT];
  assign wrPer    = wrData[PER_W-1:0];
  assign winOpen  = (winCnt != '0);
  assign unlockWr = wrEn && wrChg && wrEnb;
  assign commitWr = wrEn && !wrChg && winOpen;

  always_comb begin
    if (unlockWr)     winNext = WIN_W'(WIN_CYC);
    else if (wrEn)    winNext = '0;
    else if (winOpen) winNext = winCnt - 1'b1;
    else              winNext = '0;
  end

  always_comb begin
    if (lvl == LVL_LOCKED)    enNext = 1'b1;
    else if (commitWr)        enNext = wrEnb;
    else if (wrEn && wrEnb)   enNext = 1'b1;
    else                      enNext = enQ;
  end

  always_comb begin
    if (commitWr)                        perNext = wrPer;
    else if (wrEn && lvl == LVL_OPEN)    perNext = wrPer;
    else                                 perNext = perQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      enQ    <= (safeLevel >= 2'd2);
      perQ   <= '0;
    end else begin
      winCnt <= winNext;
      enQ    <= enNext;
      perQ   <= perNext;
    end
  end

  assign rdData         = {winOpen, enQ, perQ};
  assign cntCtl.run     = enQ;
  assign cntCtl.restart = kick;
  assign cntCtl.period  = perQ;

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !(wrEn && !wrData[CHG_BIT] && winOpen)) |=> enQ);

  // R4
  locked_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lvl == LVL_LOCKED) |-> rdData[EN_BIT]);

  // R5
  per_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lvl != LVL_OPEN && !(wrEn && !wrData[CHG_BIT] && winOpen)) |=> $stable(perQ));

  // R6
  unlock_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[CHG_BIT] && wrData[EN_BIT]) |=> rdData[CHG_BIT]);

  // R7
  commit_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[CHG_BIT]) |=> !rdData[CHG_BIT]);

  // R11
  lvl_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(lvlQ));

endmodule

// File: rtl/wdt_guard_count.sv
module wdt_guard_count
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  cntCtl_t cntCtl,
  output logic    wdtReset
);

  localparam int CNT_W = BASE_LOG2 + (1 << PER_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;
  logic             expire;

  assign lastVal = (CNT_W'(1) << (BASE_LOG2 + int'(cntCtl.period))) - CNT_W'(1);
  assign expire  = tick && (cnt >= lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      wdtReset <= 1'b0;
    end else if (!cntCtl.run || cntCtl.restart) begin
      cnt      <= '0;
      wdtReset <= 1'b0;
    end else if (expire) begin
      cnt      <= '0;
      wdtReset <= 1'b1;
    end else begin
      if (tick) cnt <= cnt + 1'b1;
      wdtReset <= 1'b0;
    end
  end

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtReset |=> !wdtReset);

  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !wdtReset);

  // R9
  kick_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntCtl.restart |=> !wdtReset);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntCtl.run |=> !wdtReset);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       safeLevel,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  input  logic             kick,
  output logic [CTL_W-1:0] rdData,
  output logic             wdtReset
);

  cntCtl_t cntCtl;

  wdt_guard_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .safeLevel (safeLevel),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .kick      (kick),
    .rdData    (rdData),
    .cntCtl    (cntCtl)
  );

  wdt_guard_count #(.BASE_LOG2(BASE_LOG2)) count_i (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .cntCtl   (cntCtl),
    .wdtReset (wdtReset)
  );

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  localparam int CLK_NS = 10;
  localparam int BASE   = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] safeLevel = 2'd0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = 5'd0;
  logic       kick = 1'b0;
  logic [4:0] rdData;
  logic       wdtReset;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // bench reference state
  int       mLvl;
  bit       mEn;
  bit [2:0] mPer;
  int       mWin;
  int       mCnt;
  bit       mRst;

  always #(CLK_NS/2) clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .safeLevel(safeLevel), .tick(tick),
    .wrEn(wrEn), .wrData(wrData), .kick(kick),
    .rdData(rdData), .wdtReset(wdtReset)
  );

  function automatic int limOf(bit [2:0] p);
    return 1 << (BASE + int'(p));
  endfunction

  function automatic bit [5:0] expOut();
    return {(mWin != 0), mEn, mPer, mRst};
  endfunction

  task automatic compare(string req);
    bit [5:0] act;
    bit [5:0] exp;
    act = {rdData, wdtReset};
    exp = expOut();
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {rd,rst} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, bit [4:0] d, bit k, bit t, string req);
    bit unl, cm;
    bit nEn;
    bit [2:0] nPer;
    int nWin;
    @(negedge clk);
    wrEn = we; wrData = d; kick = k; tick = t;
    @(posedge clk);
    unl = we && d[4] && d[3];
    cm  = we && !d[4] && (mWin > 0);
    if (!mEn || k) begin mCnt = 0; mRst = 0; end
    else if (t && mCnt >= limOf(mPer) - 1) begin mCnt = 0; mRst = 1; end
    else begin if (t) mCnt++; mRst = 0; end
    if (mLvl == 2)        nEn = 1;
    else if (cm)          nEn = d[3];
    else if (we && d[3])  nEn = 1;
    else                  nEn = mEn;
    if (cm)                     nPer = d[2:0];
    else if (we && mLvl == 0)   nPer = d[2:0];
    else                        nPer = mPer;
    if (unl)           nWin = 4;
    else if (we)       nWin = 0;
    else if (mWin > 0) nWin = mWin - 1;
    else               nWin = 0;
    mEn = nEn; mPer = nPer; mWin = nWin;
    #1;
    compare(req);
  endtask

  task automatic idle(int n, bit t, string req);
    for (int i = 0; i < n; i++) cyc(0, 5'd0, 0, t, req);
  endtask

  task automatic doReset(int lvl);
    @(negedge clk);
    safeLevel = 2'(lvl);
    wrEn = 0; wrData = 0; kick = 0; tick = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    mLvl = lvl; mEn = (lvl == 2); mPer = 0; mWin = 0; mCnt = 0; mRst = 0;
    @(negedge clk);
    rstN = 1;
    #1;
    compare("R1");
    // R11: level input moves after reset, must be ignored
    safeLevel = 2'((lvl + 1) % 3);
  endtask

  task automatic levelRun(int lvl);
    doReset(lvl);
    idle(2, 0, "R11");
    // R2: enable without unlock
    cyc(1, 5'b01_000, 0, 0, "R2");
    // R3 / R5: period write without unlock
    cyc(1, 5'b01_101, 0, 0, (lvl == 0) ? "R3" : "R5");
    // R4: clearing enable without unlock is ignored
    cyc(1, 5'b00_000, 0, 0, "R4");
    // kick, then in-window unlock and commit on 4th clock
    cyc(0, 5'd0, 1, 0, "R9");
    cyc(1, 5'b11_000, 0, 0, "R6");
    idle(3, 0, "R6");
    cyc(1, 5'b00_011, 0, 0, "R7");
    cyc(1, 5'b01_000, 0, 0, "R2");
    // late commit on 5th clock
    cyc(1, 5'b11_000, 0, 0, "R6");
    idle(4, 0, "R6");
    cyc(1, 5'b00_110, 0, 0, "R7");
    // commit with no unlock at all
    cyc(1, 5'b00_001, 0, 0, (lvl == 0) ? "R3" : "R5");
    // select period 0 through unlock
    cyc(1, 5'b11_000, 0, 0, "R6");
    cyc(1, 5'b00_000 | 5'b01_000, 0, 0, "R7");
    // timeouts with continuous ticks
    idle(3 * limOf(mPer) + 2, 1, "R8");
    // kick coinciding with expiring tick
    cyc(0, 5'd0, 1, 1, "R9");
    idle(limOf(mPer) - 1, 1, "R8");
    cyc(0, 5'd0, 1, 1, "R9");
    idle(3, 1, "R9");
    // disable and check silence
    cyc(1, 5'b11_000, 0, 0, "R6");
    cyc(1, 5'b00_000, 0, 0, "R4");
    idle(3 * limOf(mPer), 1, "R10");
  endtask

  task automatic randomRun(int lvl, int n);
    doReset(lvl);
    for (int i = 0; i < n; i++) begin
      bit we, k, t;
      bit [4:0] d;
      we = ($urandom % 6) == 0;
      d  = 5'($urandom);
      if (($urandom % 3) == 0) d[4:3] = 2'b11;
      else if (($urandom % 2) == 0) d[4] = 1'b0;
      d[2:0] = 3'($urandom % 3);
      k = ($urandom % 80) == 0;
      t = ($urandom % 2) == 0;
      cyc(we, d, k, t, "R7");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int l = 0; l < 3; l++) levelRun(l);
    for (int l = 0; l < 3; l++) randomRun(l, 4000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule